// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts ticks from one of two slow oscillators and, when software stops servicing it, raises a reset. A static selection input picks either an internal low-speed RC tick or an external 32 kHz crystal tick. Each tick of the chosen source advances a short prescaler and then a longer stage counter. A 3-bit period code taps the combined count, so that the time-out spans from 2^MIN_EXP to 2^(MIN_EXP+10) source ticks (2^8 to 2^18 by default, about 7.8 ms to 8 s at 32 kHz).

Software services the watchdog in three ways: a one-cycle clear strobe from the clear-watchdog instruction, a halt event, or a write of an invalid code to the 5-bit key register. The key register holds one of two legal codes. One code lets the watchdog count and the other stops it. Any other written value is treated as a fault and forces an immediate full reset.

On time-out the block sets a sticky time-out flag. In normal run mode it emits a full device reset pulse. In sleep or idle mode it emits only a core reset pulse, which restarts the program counter and stack pointer. The CPU, the oscillators and the reset network outside the block are plain ports. Both tick inputs are one-cycle enables in the `clk` domain.

Top module: `kwd_watchdog`

## Requirements
- R1: While `rst_n` is low, `dev_rst`, `core_rst` and `to_flag` are 0 and `wdt_on` is 1. The key register resets to 01010b, so the watchdog counts after power-up.
- R2: After a restart, the time-out happens on the 2^E-th counted tick. E is MIN_EXP+2·code for codes 0–3 and MIN_EXP+code+3 for codes 4–7, which gives 8,10,12,14,15,16,17,18 by default. The reset pulse is visible in the cycle after that tick's clock edge, and the count then starts again from zero.
- R3: On time-out with `pwr_mode` = 00 (run), `dev_rst` is high for exactly one cycle and `core_rst` stays low.
- R4: On time-out with `pwr_mode` = 01 (sleep), 10 (idle) or 11, `core_rst` is high for exactly one cycle and `dev_rst` stays low. The two reset outputs are never high together.
- R5: `to_flag` rises together with the time-out reset pulse. It then stays set until `rst_n` goes low or `clr_wdt` is sampled high.
- R6: A `clr_wdt` strobe zeroes the prescaler and the counter and clears `to_flag`, and it causes no reset. A strobe that arrives on the tick edge that would have timed out suppresses that time-out.
- R7: A `halt_evt` strobe zeroes the prescaler and the counter, causes no reset, and leaves `to_flag` unchanged. It also suppresses a time-out on the same edge.
- R8: Writing 10101b (`key_wr` with `key_data`) stops the watchdog: `wdt_on` becomes 0, the count is held at zero and no time-out occurs. Writing 01010b sets `wdt_on` to 1 and counting restarts from zero.
- R9: Writing any of the other 30 key values produces a one-cycle `dev_rst` in the next cycle, in any power mode. The write zeroes the count, leaves the key register (`wdt_on`) unchanged and leaves `to_flag` unchanged.
- R10: With `xtal_sel` = 0 only `rc_tick` advances the count. With `xtal_sel` = 1 only `xtal_tick` advances it. The tick input that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low power-on reset |
| xtal_sel | input | 1 | Static source select: 0 internal RC tick, 1 crystal tick |
| rc_tick | input | 1 | One-cycle tick from the internal low-speed RC oscillator |
| xtal_tick | input | 1 | One-cycle tick from the 32 kHz crystal oscillator |
| period_sel | input | 3 | Time-out period code |
| pwr_mode | input | 2 | Power mode: 00 run, 01 sleep, 10 idle |
| key_wr | input | 1 | Write strobe for the key register |
| key_data | input | 5 | Key value to write |
| clr_wdt | input | 1 | Clear strobe from the clear-watchdog instruction |
| halt_evt | input | 1 | Halt event strobe |
| dev_rst | output | 1 | One-cycle full device reset pulse |
| core_rst | output | 1 | One-cycle program-counter/stack-pointer reset pulse |
| to_flag | output | 1 | Sticky time-out status |
| wdt_on | output | 1 | High while the key register holds the run code |

## Verification
The assertions check several rules on every cycle. The two reset kinds are never high together, a core reset lasts a single cycle, and the time-out flag stays set and rises only with a reset pulse. A clear or an invalid key write is followed by its required response, and a stopped watchdog produces no core reset. Other behaviours can only be shown by the bench's scenarios: the exact tick count for each period code and power mode, the suppression of a time-out by a clear or halt on the terminal edge, the restart from zero after a key error, and the fact that the unselected oscillator is ignored. The bench sweeps all eight period codes in all three modes and writes every one of the 30 invalid key values.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   localparam int unsigned KEY_W  = 5;
   localparam int unsigned SEL_W  = 3;
   localparam int unsigned N_TAPS = 1 << SEL_W;
   localparam int unsigned SPAN   = 10;

   localparam logic [KEY_W-1:0] KEY_RUN = 5'b01010;
   localparam logic [KEY_W-1:0] KEY_OFF = 5'b10101;

   typedef enum logic [1:0] {
      PM_RUN   = 2'b00,
      PM_SLEEP = 2'b01,
      PM_IDLE  = 2'b10,
      PM_RSVD  = 2'b11
   } pwr_mode_e;

   // Exponent of the time-out period for one period code.
   function automatic int unsigned tap_exp(int unsigned min_exp, int unsigned code);
      return (code < 4) ? (min_exp + 2 * code) : (min_exp + code + 3);
   endfunction

   function automatic logic key_is_legal(logic [KEY_W-1:0] k);
      return (k == KEY_RUN) || (k == KEY_OFF);
   endfunction

endpackage

// File: rtl/kwd_key_ctrl.sv
module kwd_key_ctrl
   import kwd_pkg::*;
#(
   parameter logic [KEY_W-1:0] RESET_KEY = KEY_RUN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   output logic             key_err,
   output logic             run_en
);

   logic [KEY_W-1:0] key_q;

   initial begin
      assert (key_is_legal(RESET_KEY))
         else $error("kwd_key_ctrl: RESET_KEY must be a legal key code");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         key_q <= RESET_KEY;
      else if (key_wr && key_is_legal(key_data))
         key_q <= key_data;
   end

   assign key_err = key_wr && !key_is_legal(key_data);
   assign run_en  = (key_q == KEY_RUN);

   // R9: an invalid write leaves the stored key untouched
   assert_key_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      key_err |=> $stable(run_en));

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int unsigned STAGES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic carry
);

   logic [STAGES-1:0] div_q;

   initial begin
      assert (STAGES >= 2) else $error("kwd_prescaler: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (clr)
         div_q <= '0;
      else if (adv)
         div_q <= div_q + 1'b1;
   end

   assign carry = adv && (&div_q);

   // R2: the divider wraps to zero after emitting its carry
   assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      carry |=> (div_q == '0));

endmodule

// File: rtl/kwd_tap_counter.sv
module kwd_tap_counter
   import kwd_pkg::*;
#(
   parameter int unsigned MIN_EXP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             term
);

   logic [SPAN-1:0]   cnt_q;
   logic [N_TAPS-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end

   for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
      localparam int unsigned LOW = tap_exp(MIN_EXP, k) - MIN_EXP;
      if (LOW == 0) begin : g_direct
         assign hit[k] = step;
      end else begin : g_masked
         assign hit[k] = step && (&cnt_q[LOW-1:0]);
      end
   end

   assign term = hit[sel];

   // R8: a held restart keeps the counter at zero
   assert_held_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && $past(clr)) |-> (cnt_q == '0));

endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
   import kwd_pkg::*;
#(
   parameter int unsigned MIN_EXP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xtal_sel,
   input  logic             rc_tick,
   input  logic             xtal_tick,
   input  logic [SEL_W-1:0] period_sel,
   input  logic [1:0]       pwr_mode,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   input  logic             clr_wdt,
   input  logic             halt_evt,
   output logic             dev_rst,
   output logic             core_rst,
   output logic             to_flag,
   output logic             wdt_on
);

   localparam int unsigned MAX_EXP = tap_exp(MIN_EXP, N_TAPS - 1);

   initial begin
      assert (MIN_EXP >= 2 && MAX_EXP == MIN_EXP + SPAN)
         else $error("kwd_watchdog: MIN_EXP out of range");
   end

   logic      key_err, tick_sel, adv, restart, carry, term, ovf;
   logic      dev_q, core_q, to_q;
   pwr_mode_e mode;

   assign mode     = pwr_mode_e'(pwr_mode);
   assign tick_sel = xtal_sel ? xtal_tick : rc_tick;
   assign adv      = wdt_on && tick_sel;
   assign restart  = clr_wdt || halt_evt || key_err || !wdt_on;
   assign ovf      = term && !restart;

   kwd_key_ctrl #(.RESET_KEY(KEY_RUN)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (key_data),
      .key_err  (key_err),
      .run_en   (wdt_on)
   );

   kwd_prescaler #(.STAGES(MIN_EXP)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .adv   (adv),
      .carry (carry)
   );

   kwd_tap_counter #(.MIN_EXP(MIN_EXP)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart || ovf),
      .step  (carry),
      .sel   (period_sel),
      .term  (term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_q  <= 1'b0;
         core_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         dev_q  <= key_err || (ovf && mode == PM_RUN);
         core_q <= ovf && mode != PM_RUN;
         if (clr_wdt)
            to_q <= 1'b0;
         else if (ovf)
            to_q <= 1'b1;
      end
   end

   assign dev_rst  = dev_q;
   assign core_rst = core_q;
   assign to_flag  = to_q;

   assert_one_reset_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_rst, core_rst}));

   assert_core_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> !core_rst);

   assert_to_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !clr_wdt) |=> to_flag);

   assert_to_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> (dev_rst || core_rst));

   assert_clr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wdt |=> (!core_rst && !to_flag));

   assert_key_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && !key_is_legal(key_data)) |=> dev_rst);

   assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdt_on && !key_wr) |=> !core_rst);

endmodule

// File: tb/kwd_watchdog_bench.sv
module kwd_watchdog_bench;
   localparam int MIN_EXP = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       xtal_sel, rc_tick, xtal_tick, key_wr, clr_wdt, halt_evt;
   logic [2:0] period_sel;
   logic [1:0] pwr_mode;
   logic [4:0] key_data;
   logic       dev_rst, core_rst, to_flag, wdt_on;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   kwd_watchdog #(.MIN_EXP(MIN_EXP)) u_kwd_watchdog (
      .clk(clk), .rst_n(rst_n), .xtal_sel(xtal_sel), .rc_tick(rc_tick),
      .xtal_tick(xtal_tick), .period_sel(period_sel), .pwr_mode(pwr_mode),
      .key_wr(key_wr), .key_data(key_data), .clr_wdt(clr_wdt),
      .halt_evt(halt_evt), .dev_rst(dev_rst), .core_rst(core_rst),
      .to_flag(to_flag), .wdt_on(wdt_on)
   );

   function automatic int period_of(int code);
      int e;
      e = (code < 4) ? MIN_EXP + 2 * code : MIN_EXP + code + 3;
      return 1 << e;
   endfunction

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic run_pulses(int cycles, output int dp, output int cp);
      dp = 0;
      cp = 0;
      for (int i = 0; i < cycles; i++) begin
         step();
         dp += dev_rst;
         cp += core_rst;
      end
   endtask

   // Counts edges until a reset pulse is seen; returns 0 if none within limit.
   task automatic edges_to_pulse(int limit, output int n);
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         step();
         if (dev_rst || core_rst) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic measure(int code, int mode, bit src);
      int n, np;
      np = period_of(code);
      period_sel = code[2:0];
      pwr_mode   = mode[1:0];
      xtal_sel   = src;
      rc_tick    = !src;
      xtal_tick  = src;
      clr_wdt    = 1'b1;
      step();
      clr_wdt = 1'b0;
      check("R6", "to_flag after clear", to_flag, 0);
      edges_to_pulse(2 * np + 4, n);
      check("R2", $sformatf("period code %0d mode %0d src %0d", code, mode, src), n, np);
      check(mode == 0 ? "R3" : "R4", "dev_rst at time-out", dev_rst, mode == 0);
      check(mode == 0 ? "R3" : "R4", "core_rst at time-out", core_rst, mode != 0);
      check("R5", "to_flag at time-out", to_flag, 1);
      step();
      check("R3", "pulse width", dev_rst | core_rst, 0);
      check("R5", "to_flag sticky", to_flag, 1);
   endtask

   initial begin
      int n, dp, cp, np;
      rst_n = 1'b0;
      xtal_sel = 0; rc_tick = 0; xtal_tick = 0; key_wr = 0; key_data = 0;
      clr_wdt = 0; halt_evt = 0; period_sel = 0; pwr_mode = 0;
      repeat (3) step();
      check("R1", "dev_rst in reset", dev_rst, 0);
      check("R1", "core_rst in reset", core_rst, 0);
      check("R1", "to_flag in reset", to_flag, 0);
      check("R1", "wdt_on in reset", wdt_on, 1);
      rst_n = 1'b1;
      step();

      // R2/R3/R4: every period code in every power mode, alternating source
      for (int mode = 0; mode < 3; mode++)
         for (int code = 0; code < 8; code++)
            measure(code, mode, bit'((code + mode) % 2));

      // R10: unselected tick has no effect
      measure(0, 0, 1'b0);
      rc_tick = 0; xtal_tick = 1; xtal_sel = 0;
      run_pulses(40, dp, cp);
      check("R10", "pulses from unselected crystal tick", dp + cp, 0);
      xtal_sel = 1; xtal_tick = 0; rc_tick = 1;
      run_pulses(40, dp, cp);
      check("R10", "pulses from unselected RC tick", dp + cp, 0);

      // R6: clear on the terminal tick edge suppresses the time-out
      np = period_of(1);
      period_sel = 3'd1; pwr_mode = 2'd1; xtal_sel = 0; rc_tick = 1; xtal_tick = 0;
      clr_wdt = 1; step(); clr_wdt = 0;
      repeat (np - 1) step();
      clr_wdt = 1; step(); clr_wdt = 0;
      check("R6", "no reset when clear meets terminal edge", dev_rst | core_rst, 0);
      edges_to_pulse(2 * np, n);
      check("R6", "full period after clear", n, np);
      run_pulses(1, dp, cp);
      run_pulses(0, dp, cp);
      for (int i = 0; i < 20; i++) begin
         clr_wdt = (i % 3 == 0);
         step();
      end
      clr_wdt = 0;
      check("R6", "periodic clears keep TO low", to_flag, 0);

      // R7: halt clears the count but keeps TO
      measure(0, 0, 1'b0);
      np = period_of(0);
      for (int i = 0; i < 30; i++) begin
         halt_evt = (i % 3 == 0);
         step();
         dp += dev_rst;
         cp += core_rst;
      end
      halt_evt = 0;
      check("R7", "pulses under periodic halt", dp + cp, 0);
      check("R7", "to_flag kept by halt", to_flag, 1);
      halt_evt = 1; step(); halt_evt = 0;
      repeat (np - 1) step();
      halt_evt = 1; step(); halt_evt = 0;
      check("R7", "no reset when halt meets terminal edge", dev_rst | core_rst, 0);
      edges_to_pulse(2 * np, n);
      check("R7", "full period after halt", n, np);

      // R8: stop and restart through the key register
      step();
      key_wr = 1; key_data = 5'b10101; step(); key_wr = 0;
      check("R8", "wdt_on after stop code", wdt_on, 0);
      check("R8", "stop code is no reset", dev_rst, 0);
      run_pulses(100, dp, cp);
      check("R8", "pulses while stopped", dp + cp, 0);
      key_wr = 1; key_data = 5'b01010; step(); key_wr = 0;
      check("R8", "wdt_on after run code", wdt_on, 1);
      check("R8", "run code is no reset", dev_rst, 0);
      edges_to_pulse(4 * np, n);
      check("R8", "period after restart", n, np);

      // R9: every invalid key value, in sleep mode, ticks stopped
      step();
      rc_tick = 0; pwr_mode = 2'd1;
      for (int v = 0; v < 32; v++) begin
         if (v == 5'b01010 || v == 5'b10101) continue;
         key_wr = 1; key_data = v[4:0]; step(); key_wr = 0;
         check("R9", $sformatf("dev_rst after key %0d", v), dev_rst, 1);
         check("R9", $sformatf("core_rst after key %0d", v), core_rst, 0);
         check("R9", $sformatf("wdt_on after key %0d", v), wdt_on, 1);
         check("R9", $sformatf("to_flag after key %0d", v), to_flag, 1);
         step();
         check("R9", "key reset width", dev_rst, 0);
      end

      // R9: key error restarts the count and does not set TO
      np = period_of(1);
      period_sel = 3'd1; pwr_mode = 2'd0; rc_tick = 1;
      clr_wdt = 1; step(); clr_wdt = 0;
      repeat (np - 3) step();
      key_wr = 1; key_data = 5'b11111; step(); key_wr = 0;
      check("R9", "key error pulse", dev_rst, 1);
      check("R9", "key error leaves TO low", to_flag, 0);
      edges_to_pulse(2 * np, n);
      check("R9", "full period after key error", n, np);

      // R9: invalid write while stopped keeps it stopped
      step();
      key_wr = 1; key_data = 5'b10101; step();
      key_data = 5'b00001; step(); key_wr = 0;
      check("R9", "invalid write while stopped pulses", dev_rst, 1);
      check("R9", "invalid write keeps stop code", wdt_on, 0);

      // R5: power-on reset clears TO
      rst_n = 0; step();
      check("R5", "to_flag after power-on reset", to_flag, 0);
      check("R1", "wdt_on after power-on reset", wdt_on, 1);
      rst_n = 1; step();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule